// File: doc/BRIEF.md
# Asynchronous Serial Receive Framer

This block turns an asynchronous serial line into parallel characters. The incoming line first passes through a two-stage synchronizer. A 16x oversampling tick drives a frame state machine that finds the start bit and confirms it at its centre. The machine then takes each data bit, an optional parity bit and the stop bit at the centre of its bit period. A finished character is written into a holding register. That write sets a ready flag for the host, and it updates the sticky flags for overrun, framing, parity and break.

Three configuration inputs are read while a character is in progress, so they must stay stable from the start bit to the stop bit:
- character length: the full data width, or one bit shorter;
- parity enable;
- parity sense: odd or even.

The host reads the holding register with a read strobe, which clears the ready flag. It clears the sticky error flags with a clear strobe. A new character always replaces the holding register. If the previous character was never read, the block flags an overrun and keeps the new character; it does not drop it.

Top module: `sio_rx`

## Requirements
- R1: The line idles at 1. A character starts on a 1-to-0 transition of the synchronized line. The line is sampled again 8 ticks later, at mid start bit. If it reads 1 there, the frame is dropped, no character is delivered, and the receiver returns to idle.
- R2: Data bits arrive least significant bit first, one every 16 ticks. With `cfg_short`=0, 8 bits go to `rx_data[7:0]`. With `cfg_short`=1, 7 bits go to `rx_data[6:0]` and `rx_data[7]` reads 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_odd`=0, the data bits plus the parity bit must hold an even number of ones; with `cfg_par_odd`=1, an odd number. A mismatch sets `rx_parity_err`.
- R4: After reset, `rx_data` is 0 and every flag output is 0. When the stop bit is sampled, the character is loaded into `rx_data` and `rx_ready` is 1 from the following cycle.
- R5: `rd_stb` clears `rx_ready` in the next cycle and leaves `rx_data` unchanged. `rx_data` changes only when a character is loaded.
- R6: Suppose a character is loaded while `rx_ready` is 1 and `rd_stb` is low in that cycle. Then `rx_overrun` is set, and `rx_data` takes the new character.
- R7: A stop-bit sample of 0 sets `rx_framing_err`.
- R8: Suppose every data bit, the parity bit (when enabled) and the stop bit are all 0. Then `rx_break` is set, together with `rx_framing_err`.
- R9: The overrun, framing, parity and break flags hold until `flag_clr`. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line |
| cfg_short | input | 1 | 1 selects characters one bit shorter than DATA_W |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| rd_stb | input | 1 | Read of the holding register, clears ready |
| flag_clr | input | 1 | Clears the sticky error flags |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Unread character present |
| rx_overrun | output | 1 | Sticky overrun flag |
| rx_framing_err | output | 1 | Sticky framing error flag |
| rx_parity_err | output | 1 | Sticky parity error flag |
| rx_break | output | 1 | Sticky break flag |

## Verification
Each kind of internal fault shows up in a different place at the ports:
- An oversample or bit counter that drifts by one moves the sampling point. This shows at the next load as shifted or doubled bits in `rx_data`, or as a framing error, about one character time after the fault.
- A wrong ready state shows up within one character as a missing or spurious overrun. It also shows up as a ready flag that survives a read.
- A parity or break decision computed from the wrong bits shows as a flag that disagrees with the line pattern, in the cycle after the stop sample.

The bench sends known frames of each length and parity mode and compares every load against a queue of expected results.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  // widest character the helper functions handle
  localparam int MAX_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // parity bit that a correct sender appends to d
  function automatic logic want_parity(input logic [MAX_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // true when the whole frame after the start bit was held low
  function automatic logic line_held_low(input logic [MAX_W-1:0] d, input logic par_en,
                                         input logic par, input logic stop);
    return (d == '0) && !stop && !(par_en && par);
  endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sio_rx_framer.sv
module sio_rx_framer
  import sio_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_s,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              char_load,
  output logic [DATA_W-1:0] char_data,
  output logic              stop_smp,
  output logic              par_bad,
  output logic              brk_evt,
  output logic              start_abort
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(OVS / 2 - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_smp;
  logic              rx_prev;

  logic              fall_seen;
  logic              bit_mid;
  logic              start_mid;
  logic [IDX_W-1:0]  last_idx;

  assign fall_seen = rx_prev && !rx_s;
  assign bit_mid   = tick && (cnt == LAST_CNT);
  assign start_mid = tick && (cnt == HALF_CNT);
  assign last_idx  = cfg_short ? IDX_W'(DATA_W - 2) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_smp <= 1'b0;
      rx_prev <= 1'b1;
    end else if (tick) begin
      rx_prev <= rx_s;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (fall_seen) state <= ST_START;
        end
        ST_START: begin
          if (start_mid) begin
            cnt <= '0;
            idx <= '0;
            state <= rx_s ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (bit_mid) begin
            cnt   <= '0;
            shreg <= {rx_s, shreg[DATA_W-1:1]};
            idx   <= idx + 1'b1;
            if (idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (bit_mid) begin
            cnt     <= '0;
            par_smp <= rx_s;
            state   <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (bit_mid) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // short characters land in the upper bits; realign to bit 0
  assign char_data   = cfg_short ? (shreg >> 1) : shreg;
  assign char_load   = bit_mid && (state == ST_STOP);
  assign start_abort = start_mid && (state == ST_START) && rx_s;
  assign stop_smp    = rx_s;
  assign par_bad     = cfg_par_en && (par_smp != want_parity(MAX_W'(char_data), cfg_par_odd));
  assign brk_evt     = line_held_low(MAX_W'(char_data), cfg_par_en, par_smp, rx_s);

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_load,
  input  logic [DATA_W-1:0] char_data,
  input  logic              stop_smp,
  input  logic              par_bad,
  input  logic              brk_evt,
  input  logic              rd_stb,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun,
  output logic              rx_framing_err,
  output logic              rx_parity_err,
  output logic              rx_break
);

  localparam int NFLAG = 4;

  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
    end else if (char_load) begin
      rx_data  <= char_data;
      rx_ready <= 1'b1;
    end else if (rd_stb) begin
      rx_ready <= 1'b0;
    end
  end

  // set conditions: overrun, framing, parity, break
  assign flag_set[0] = char_load && rx_ready && !rd_stb;
  assign flag_set[1] = char_load && !stop_smp;
  assign flag_set[2] = char_load && par_bad;
  assign flag_set[3] = char_load && brk_evt;

  for (genvar i = 0; i < NFLAG; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[i] <= 1'b0;
      else if (flag_set[i]) flag_q[i] <= 1'b1;
      else if (flag_clr)    flag_q[i] <= 1'b0;
    end
  end

  assign rx_overrun     = flag_q[0];
  assign rx_framing_err = flag_q[1];
  assign rx_parity_err  = flag_q[2];
  assign rx_break       = flag_q[3];

endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rxd,
  input  logic              cfg_short,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              rd_stb,
  input  logic              flag_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_overrun,
  output logic              rx_framing_err,
  output logic              rx_parity_err,
  output logic              rx_break
);

  // named internal events, visible to the bound checker
  logic              rx_s;
  logic              char_load;
  logic [DATA_W-1:0] char_data;
  logic              stop_smp;
  logic              par_bad;
  logic              brk_evt;
  logic              start_abort;

  sio_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rx_s)
  );

  sio_rx_framer #(.DATA_W(DATA_W), .OVS(OVS)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (baud_tick),
    .rx_s       (rx_s),
    .cfg_short  (cfg_short),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .char_load  (char_load),
    .char_data  (char_data),
    .stop_smp   (stop_smp),
    .par_bad    (par_bad),
    .brk_evt    (brk_evt),
    .start_abort(start_abort)
  );

  sio_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk           (clk),
    .rst_n         (rst_n),
    .char_load     (char_load),
    .char_data     (char_data),
    .stop_smp      (stop_smp),
    .par_bad       (par_bad),
    .brk_evt       (brk_evt),
    .rd_stb        (rd_stb),
    .flag_clr      (flag_clr),
    .rx_data       (rx_data),
    .rx_ready      (rx_ready),
    .rx_overrun    (rx_overrun),
    .rx_framing_err(rx_framing_err),
    .rx_parity_err (rx_parity_err),
    .rx_break      (rx_break)
  );

endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              flag_clr,
  input logic              char_load,
  input logic              stop_smp,
  input logic              par_bad,
  input logic              brk_evt,
  input logic              start_abort,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              rx_overrun,
  input logic              rx_framing_err,
  input logic              rx_parity_err,
  input logic              rx_break
);

  AST_ABORT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_abort |-> !char_load); // R1
  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    char_load && par_bad |=> rx_parity_err); // R3
  AST_LOAD_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    char_load |=> rx_ready); // R4
  AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !char_load |=> !rx_ready); // R5
  AST_DATA_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !char_load |=> $stable(rx_data)); // R5
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    char_load && rx_ready && !rd_stb |=> rx_overrun); // R6
  AST_FRAMING_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    char_load && !stop_smp |=> rx_framing_err); // R7
  AST_BREAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    char_load && brk_evt |=> rx_break && rx_framing_err); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !flag_clr |=> rx_overrun); // R9
  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !char_load |=> !rx_overrun && !rx_framing_err && !rx_parity_err && !rx_break); // R9

endmodule

bind sio_rx sio_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_stb        (rd_stb),
  .flag_clr      (flag_clr),
  .char_load     (char_load),
  .stop_smp      (stop_smp),
  .par_bad       (par_bad),
  .brk_evt       (brk_evt),
  .start_abort   (start_abort),
  .rx_data       (rx_data),
  .rx_ready      (rx_ready),
  .rx_overrun    (rx_overrun),
  .rx_framing_err(rx_framing_err),
  .rx_parity_err (rx_parity_err),
  .rx_break      (rx_break)
);

// File: tb/sio_rx_bench.sv
module sio_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       rxd = 1'b1;
  logic       cfg_short = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_stb = 1'b0;
  logic       flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, rx_overrun, rx_framing_err, rx_parity_err, rx_break;

  typedef struct packed {
    logic [7:0] d;
    logic       pe;
    logic       fe;
    logic       bk;
    logic       ov;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   mon_hold = 1'b0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  sio_rx u_sio_rx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_short(cfg_short), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_stb(rd_stb), .flag_clr(flag_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rx_framing_err(rx_framing_err),
    .rx_parity_err(rx_parity_err), .rx_break(rx_break)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  // driver: one frame, 16 clocks per bit with the tick always on
  task automatic send_char(input logic [7:0] d, input bit seven, input bit pe, input bit po,
                           input bit flip, input bit stopv, input bit push);
    logic [7:0] dm;
    logic       pbit;
    int         nb;
    exp_t       e;
    dm   = seven ? (d & 8'h7F) : d;
    nb   = seven ? 7 : 8;
    pbit = (^dm) ^ po ^ flip;
    @(negedge clk);
    cfg_short = seven; cfg_par_en = pe; cfg_par_odd = po;
    e.d  = dm;
    e.pe = pe && flip;
    e.fe = !stopv;
    e.bk = (dm == 8'h00) && !stopv && !(pe && pbit);
    e.ov = 1'b0;
    if (push) exp_q.push_back(e);
    repeat (4) @(negedge clk);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = dm[i];
      repeat (16) @(negedge clk);
    end
    if (pe) begin
      rxd = pbit;
      repeat (16) @(negedge clk);
    end
    rxd = stopv;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  // monitor: compare each delivered character, then read and clear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rx_ready && !mon_hold) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected character", 32'(rx_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(rx_data == e.d, "R2 data bits", 32'(rx_data), 32'(e.d));
          check(rx_parity_err == e.pe, "R3 parity flag", 32'(rx_parity_err), 32'(e.pe));
          check(rx_framing_err == e.fe, "R7 framing flag", 32'(rx_framing_err), 32'(e.fe));
          check(rx_break == e.bk, "R8 break flag", 32'(rx_break), 32'(e.bk));
          check(rx_overrun == e.ov, "R6 overrun flag", 32'(rx_overrun), 32'(e.ov));
        end
        rd_stb = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; flag_clr = 1'b0;
        check(!rx_ready, "R5 ready cleared by read", 32'(rx_ready), 0);
        check(rx_data == e.d, "R5 read keeps data", 32'(rx_data), 32'(e.d));
        check({rx_overrun, rx_framing_err, rx_parity_err, rx_break} == 4'b0,
              "R9 flags cleared", 32'({rx_overrun, rx_framing_err, rx_parity_err, rx_break}), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    exp_t e;
    repeat (5) @(negedge clk);
    // R4: reset state
    check(rx_data == 8'h00 && !rx_ready, "R4 reset data/ready", 32'({rx_ready, rx_data}), 0);
    check({rx_overrun, rx_framing_err, rx_parity_err, rx_break} == 4'b0, "R4 reset flags",
          32'({rx_overrun, rx_framing_err, rx_parity_err, rx_break}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    send_char(8'hA5, 0, 0, 0, 0, 1, 1);   // R2 8-bit, no parity
    send_char(8'h3C, 0, 1, 0, 0, 1, 1);   // R3 even parity, good
    send_char(8'h81, 0, 1, 1, 0, 1, 1);   // R3 odd parity, good
    send_char(8'hD5, 1, 0, 0, 0, 1, 1);   // R2 7-bit, top bit dropped
    send_char(8'h13, 1, 1, 1, 0, 1, 1);   // R2 R3 7-bit odd parity
    send_char(8'h6E, 0, 1, 0, 1, 1, 1);   // R3 even parity mismatch
    send_char(8'h70, 0, 1, 1, 1, 1, 1);   // R3 odd parity mismatch
    send_char(8'h42, 0, 0, 0, 0, 0, 1);   // R7 stop sampled low
    send_char(8'h00, 0, 1, 0, 0, 0, 1);   // R8 break with parity
    send_char(8'h00, 1, 0, 0, 0, 0, 1);   // R8 break, 7-bit no parity

    // R1: a low pulse shorter than half a bit must not start a frame
    @(negedge clk);
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (60) @(negedge clk);
    check(!rx_ready, "R1 glitch ignored", 32'(rx_ready), 0);
    send_char(8'h5A, 0, 0, 0, 0, 1, 1);   // R1 recovery after glitch

    // R6: second character lands while the first is unread
    mon_hold = 1'b1;
    send_char(8'h11, 0, 0, 0, 0, 1, 0);
    send_char(8'hE7, 0, 0, 0, 0, 1, 0);
    check(rx_ready, "R6 ready still set", 32'(rx_ready), 1);
    e.d = 8'hE7; e.pe = 1'b0; e.fe = 1'b0; e.bk = 1'b0; e.ov = 1'b1;
    exp_q.push_back(e);
    mon_hold = 1'b0;

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 all characters delivered", 32'(exp_q.size()), 0);
    check(!rx_ready, "R5 idle at end", 32'(rx_ready), 0);
    summary();
  end

endmodule